// File: doc/BRIEF.md
# Data Lane Burst Sequencer

This block steers one data lane of a serial camera link through a single high-speed burst. While idle, the lane rests in the low-power stop state (both single-ended lines high). A burst starts only when two things are true: the clock lane reports that it is running, and a burst request is present. The sequencer then drives the low-power request state and the low-power prepare state. Next it drives the differential HS-0 level for the zero period and emits one sync byte. After that it forwards payload bytes from a byte-wide valid/ready stream.

Once the final payload byte has been accepted, the lane drives the trail level for a programmed number of byte-clock cycles. The trail level is the complement of the last bit put on the wire. The lane then returns to the stop state and holds it for the exit period. Only after that can a new request be honoured. A downstream serializer turns `hs_byte` into bits, least significant bit first, whenever `hs_en` is high. The electrical layer is out of scope.

All durations are counted in byte-clock cycles. One byte-clock cycle spans `UI_PER_BYTE` unit intervals. Each software value supplies the fixed-time part of a limit. The block adds the part that scales with unit intervals, rounded up to whole cycles. For the trail it also enforces the lower bound that depends only on unit intervals.

Top module: `dlane_burst_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the lane is in the stop state: `lp_p`=1, `lp_n`=1, `hs_en`=0, `pl_ready`=0.
- R2: A request raised while `clk_lane_rdy` is low has no effect. The lane stays in the stop state until the flag rises.
- R3: The request state (`lp_p`=0, `lp_n`=1) lasts max(`cfg_lpx`,1) cycles.
- R4: The prepare state (`lp_p`=0, `lp_n`=0, `hs_en`=0) lasts `cfg_prep`+1 cycles and comes directly before the first high-speed cycle.
- R5: The zero period (`hs_en`=1, `hs_byte`=0x00) lasts `cfg_zero`+1 cycles.
- R6: Exactly one cycle with `hs_byte`=0xB8 follows the zero period.
- R7: `pl_ready` is 1 only in the payload phase. There, `hs_byte` equals `pl_data`. The beat that is accepted with `pl_last`=1 ends the payload phase.
- R8: After the last beat, `hs_en`=1 and every bit of `hs_byte` equals the inverse of bit 7 of that beat. This lasts max(1, `cfg_trail`+1) cycles.
- R9: After the trail, the stop state is held. With a request already pending, the next request state appears after max(`cfg_exit`,1)+1 stop-state cycles. With no request, the lane stays in the stop state.
- R10: Whenever `hs_en` is 1, both `lp_p` and `lp_n` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_lane_rdy | input | 1 | Clock lane is running in high-speed mode |
| burst_req | input | 1 | Request to start a burst |
| cfg_lpx | input | CNT_W | Request state length, cycles |
| cfg_prep | input | CNT_W | Prepare time term, cycles |
| cfg_zero | input | CNT_W | Zero time term, cycles |
| cfg_trail | input | CNT_W | Trail time term, cycles |
| cfg_exit | input | CNT_W | Stop state hold after a burst, cycles |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Marks the final payload byte |
| pl_ready | output | 1 | Payload byte accepted this cycle when valid |
| lp_p | output | 1 | Low-power level, positive line |
| lp_n | output | 1 | Low-power level, negative line |
| hs_en | output | 1 | High-speed driver enable |
| hs_byte | output | 8 | Byte for the serializer, LSB first |

## Verification
The assertions take for granted three things about the inputs. The payload stream holds `pl_valid` high from the first payload cycle through the beat carrying `pl_last`. The configuration inputs do not change while a duration is being loaded. Reset is held for at least one clock edge at start-up. The stimulus presents every beat of a burst before the payload phase begins and advances the data only after the edge that accepts it. It changes the configuration only in the first stop-state cycle after a trail, when the exit length is already captured and the next request length is not yet loaded.

// File: rtl/dls_pkg.sv
// Package: shared state encoding and constants for the data lane burst sequencer.
// Assumes: a byte clock, with bytes serialized LSB first downstream.
package dls_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_PREP,
        ST_ZERO,
        ST_SYNC,
        ST_PAYLD,
        ST_TRAIL,
        ST_EXIT
    } dls_state_e;

endpackage

// File: rtl/dls_dur.sv
// Module: converts one programmed time term into a cycle count.
// It adds a fixed per-bit term and clamps the result to a lower bound.
// Assumes: ADD and MIN are small non-negative integers; the result is one bit
// wider than the input, so the sum never wraps.
module dls_dur #(
    parameter int W   = 8,
    parameter int ADD = 0,
    parameter int MIN = 1
) (
    input  logic [W-1:0] cfg,
    output logic [W:0]   dur
);

    localparam logic [W:0] ADD_V = (W+1)'(ADD);
    localparam logic [W:0] MIN_V = (W+1)'(MIN);

    logic [W:0] sum;

    // Sum of the time term and the per-bit term, then the lower clamp.
    always_comb begin
        sum = {1'b0, cfg} + ADD_V;
        dur = (sum < MIN_V) ? MIN_V : sum;
    end

endmodule

// File: rtl/dls_timer.sv
// Module: loadable down-counter that times one phase of the burst.
// After a load of value D, done is high in the D-th cycle of the phase.
// Assumes: load_val is at least 1.
module dls_timer #(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [W:0] load_val,
    output logic       done
);

    logic [W:0] cnt_q;

    // Load the remaining count on a phase change, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dls_fsm.sv
// Module: burst phase controller. It walks stop -> request -> prepare -> zero
// -> sync -> payload -> trail -> exit, and loads the phase timer on each
// timed entry.
// Assumes: pl_valid stays high during the payload phase until the last beat.
module dls_fsm
    import dls_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_lane_rdy,
    input  logic       burst_req,
    input  logic       pl_valid,
    input  logic       pl_last,
    input  logic       tmr_done,
    input  logic [W:0] d_req,
    input  logic [W:0] d_prep,
    input  logic [W:0] d_zero,
    input  logic [W:0] d_trail,
    input  logic [W:0] d_exit,
    output logic       tmr_load,
    output logic [W:0] tmr_val,
    output dls_state_e state
);

    dls_state_e state_d;

    // Next phase and the timer load that goes with it.
    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = d_req;
        unique case (state)
            ST_IDLE: if (clk_lane_rdy && burst_req) begin
                state_d  = ST_REQ;
                tmr_load = 1'b1;
                tmr_val  = d_req;
            end
            ST_REQ: if (tmr_done) begin
                state_d  = ST_PREP;
                tmr_load = 1'b1;
                tmr_val  = d_prep;
            end
            ST_PREP: if (tmr_done) begin
                state_d  = ST_ZERO;
                tmr_load = 1'b1;
                tmr_val  = d_zero;
            end
            ST_ZERO:  if (tmr_done) state_d = ST_SYNC;
            ST_SYNC:  state_d = ST_PAYLD;
            ST_PAYLD: if (pl_valid && pl_last) begin
                state_d  = ST_TRAIL;
                tmr_load = 1'b1;
                tmr_val  = d_trail;
            end
            ST_TRAIL: if (tmr_done) begin
                state_d  = ST_EXIT;
                tmr_load = 1'b1;
                tmr_val  = d_exit;
            end
            ST_EXIT:  if (tmr_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

endmodule

// File: rtl/dlane_burst_seq.sv
// Module: top of the data lane burst sequencer. It turns the programmed time
// terms into cycle counts, adding the unit-interval parts, and runs the phase
// controller. It decodes the line levels and the byte for the serializer.
// Assumes: one byte clock spans UI_PER_BYTE unit intervals; configuration is
// stable while a phase length is loaded.
module dlane_burst_seq
    import dls_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int UI_PER_BYTE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_lane_rdy,
    input  logic              burst_req,
    input  logic [CNT_W-1:0]  cfg_lpx,
    input  logic [CNT_W-1:0]  cfg_prep,
    input  logic [CNT_W-1:0]  cfg_zero,
    input  logic [CNT_W-1:0]  cfg_trail,
    input  logic [CNT_W-1:0]  cfg_exit,
    input  logic              pl_valid,
    input  logic [BYTE_W-1:0] pl_data,
    input  logic              pl_last,
    output logic              pl_ready,
    output logic              lp_p,
    output logic              lp_n,
    output logic              hs_en,
    output logic [BYTE_W-1:0] hs_byte
);

    // Per-bit terms in whole byte-clock cycles, rounded up.
    localparam int PREP_ADD  = (4 + UI_PER_BYTE - 1) / UI_PER_BYTE;
    localparam int PZ_ADD    = (10 + UI_PER_BYTE - 1) / UI_PER_BYTE;
    localparam int ZERO_ADD  = PZ_ADD - PREP_ADD;
    localparam int TRAIL_ADD = (4 + UI_PER_BYTE - 1) / UI_PER_BYTE;
    localparam int TRAIL_MIN = (8 + UI_PER_BYTE - 1) / UI_PER_BYTE;

    logic [CNT_W:0] d_req, d_prep, d_zero, d_trail, d_exit;
    logic           tmr_load, tmr_done;
    logic [CNT_W:0] tmr_val;
    dls_state_e     state;
    logic           trail_bit;

    dls_dur #(.W(CNT_W), .ADD(0), .MIN(1)) u_dur_req (
        .cfg(cfg_lpx), .dur(d_req));
    dls_dur #(.W(CNT_W), .ADD(PREP_ADD), .MIN(1)) u_dur_prep (
        .cfg(cfg_prep), .dur(d_prep));
    dls_dur #(.W(CNT_W), .ADD(ZERO_ADD), .MIN(1)) u_dur_zero (
        .cfg(cfg_zero), .dur(d_zero));
    dls_dur #(.W(CNT_W), .ADD(TRAIL_ADD), .MIN(TRAIL_MIN)) u_dur_trail (
        .cfg(cfg_trail), .dur(d_trail));
    dls_dur #(.W(CNT_W), .ADD(0), .MIN(1)) u_dur_exit (
        .cfg(cfg_exit), .dur(d_exit));

    dls_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dls_fsm #(.W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_lane_rdy (clk_lane_rdy),
        .burst_req    (burst_req),
        .pl_valid     (pl_valid),
        .pl_last      (pl_last),
        .tmr_done     (tmr_done),
        .d_req        (d_req),
        .d_prep       (d_prep),
        .d_zero       (d_zero),
        .d_trail      (d_trail),
        .d_exit       (d_exit),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .state        (state)
    );

    // Remember the inverse of the last bit put on the wire (MSB of each beat).
    always_ff @(posedge clk) begin
        if (!rst_n)
            trail_bit <= 1'b0;
        else if (pl_valid && pl_ready)
            trail_bit <= ~pl_data[BYTE_W-1];
    end

    // Line levels, driver enable, ready and the byte for the serializer.
    always_comb begin
        lp_p     = 1'b1;
        lp_n     = 1'b1;
        hs_en    = 1'b0;
        hs_byte  = '0;
        pl_ready = 1'b0;
        unique case (state)
            ST_REQ:   lp_p = 1'b0;
            ST_PREP:  begin lp_p = 1'b0; lp_n = 1'b0; end
            ST_ZERO:  begin lp_p = 1'b0; lp_n = 1'b0; hs_en = 1'b1; end
            ST_SYNC:  begin
                lp_p = 1'b0; lp_n = 1'b0; hs_en = 1'b1;
                hs_byte = SYNC_BYTE;
            end
            ST_PAYLD: begin
                lp_p = 1'b0; lp_n = 1'b0; hs_en = 1'b1;
                hs_byte  = pl_data;
                pl_ready = 1'b1;
            end
            ST_TRAIL: begin
                lp_p = 1'b0; lp_n = 1'b0; hs_en = 1'b1;
                hs_byte = {BYTE_W{trail_bit}};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dls_chk.sv
// Module: property checker for the data lane burst sequencer, bound to the top.
// Assumes: reset is low during the first clock edges.
module dls_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_lane_rdy,
    input logic       burst_req,
    input logic       pl_valid,
    input logic [7:0] pl_data,
    input logic       pl_last,
    input logic       pl_ready,
    input logic       lp_p,
    input logic       lp_n,
    input logic       hs_en,
    input logic [7:0] hs_byte
);

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lp_p) && lp_n) |-> $past(clk_lane_rdy && burst_req)); // R2

    AST_PREP_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(!lp_p && !lp_n && !hs_en)); // R4

    AST_SYNC_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !pl_ready && hs_byte == 8'hB8) |-> $past(hs_en && hs_byte == 8'h00)); // R6

    AST_READY_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> hs_en); // R7

    AST_TRAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pl_valid && pl_ready && pl_last) |->
            (hs_en && !pl_ready && hs_byte == {8{~$past(pl_data[7])}})); // R8

    AST_HS_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (!lp_p && !lp_n)); // R10

endmodule

bind dlane_burst_seq dls_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_lane_rdy (clk_lane_rdy),
    .burst_req    (burst_req),
    .pl_valid     (pl_valid),
    .pl_data      (pl_data),
    .pl_last      (pl_last),
    .pl_ready     (pl_ready),
    .lp_p         (lp_p),
    .lp_n         (lp_n),
    .hs_en        (hs_en),
    .hs_byte      (hs_byte)
);

// File: tb/sim_dlane_burst_seq.sv
// Bench: chained burst sweep over every small configuration combination.
// Phase lengths are measured at the ports and compared with arithmetic.
module sim_dlane_burst_seq;

    localparam int CW = 8;
    localparam int NB = 162;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_lane_rdy, burst_req;
    logic [CW-1:0] cfg_lpx, cfg_prep, cfg_zero, cfg_trail, cfg_exit;
    logic          pl_valid, pl_last;
    logic [7:0]    pl_data;
    logic          pl_ready, lp_p, lp_n, hs_en;
    logic [7:0]    hs_byte;

    int   nvec = 0;
    int   nerr = 0;
    bit   finished = 1'b0;
    logic [7:0] bdat [0:3];
    int   blen;
    int   n;
    int   exp_gap;
    bit   bad_rdy;

    always #2 clk = ~clk;

    dlane_burst_seq #(.CNT_W(CW), .UI_PER_BYTE(8)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_lane_rdy(clk_lane_rdy),
        .burst_req(burst_req), .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep),
        .cfg_zero(cfg_zero), .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
        .pl_ready(pl_ready), .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en),
        .hs_byte(hs_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Set up configuration and payload for burst k.
    task automatic setup_burst(input int k);
        cfg_lpx   = CW'(k % 3);
        cfg_prep  = CW'((k / 3) % 2);
        cfg_zero  = CW'((k / 6) % 3);
        cfg_trail = CW'((k / 18) % 3);
        cfg_exit  = CW'((k / 54) % 3);
        blen = 1 + (k % 3);
        for (int i = 0; i < 4; i++) bdat[i] = 8'(k * 37 + i * 91 + 5);
        pl_valid = 1'b1;
        pl_data  = bdat[0];
        pl_last  = (blen == 1);
    endtask

    initial begin
        rst_n = 1'b0; clk_lane_rdy = 1'b0; burst_req = 1'b0;
        pl_valid = 1'b0; pl_last = 1'b0; pl_data = '0;
        cfg_lpx = '0; cfg_prep = '0; cfg_zero = '0; cfg_trail = '0; cfg_exit = '0;
        repeat (3) @(negedge clk);
        chk(lp_p && lp_n && !hs_en && !pl_ready, "R1", {lp_p, lp_n, hs_en, pl_ready}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lp_p && lp_n && !hs_en && !pl_ready, "R1", {lp_p, lp_n, hs_en, pl_ready}, 4'b1100);

        // R2: request with clock lane not ready is ignored.
        burst_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(lp_p && lp_n && !hs_en && !pl_ready, "R2", {lp_p, lp_n}, 3);
        end

        setup_burst(0);
        clk_lane_rdy = 1'b1;
        exp_gap = 0;
        @(negedge clk);

        for (int k = 0; k < NB; k++) begin
            // R9: stop-state cycles before this request state.
            n = 0; bad_rdy = 1'b0;
            while (lp_p && lp_n && n < 100) begin
                if (pl_ready) bad_rdy = 1'b1;
                n++; @(negedge clk);
            end
            chk(n == exp_gap, "R9", n, exp_gap);

            // R3: request state length.
            n = 0;
            while (!lp_p && lp_n && n < 100) begin
                if (pl_ready) bad_rdy = 1'b1;
                n++; @(negedge clk);
            end
            chk(n == ((cfg_lpx == 0) ? 1 : int'(cfg_lpx)), "R3", n,
                (cfg_lpx == 0) ? 1 : int'(cfg_lpx));

            // R4: prepare state length.
            n = 0;
            while (!lp_p && !lp_n && !hs_en && n < 100) begin
                if (pl_ready) bad_rdy = 1'b1;
                n++; @(negedge clk);
            end
            chk(n == int'(cfg_prep) + 1, "R4", n, int'(cfg_prep) + 1);

            // R5: zero period length.
            n = 0;
            while (hs_en && hs_byte == 8'h00 && !pl_ready && n < 100) begin
                if (lp_p || lp_n) bad_rdy = 1'b1;
                n++; @(negedge clk);
            end
            chk(n == int'(cfg_zero) + 1, "R5", n, int'(cfg_zero) + 1);

            // R6 and R10: single sync byte with both low-power lines low.
            chk(hs_en && hs_byte == 8'hB8 && !pl_ready, "R6", hs_byte, 8'hB8);
            chk(!lp_p && !lp_n, "R10", {lp_p, lp_n}, 0);
            chk(!bad_rdy, "R7", bad_rdy, 0);
            @(negedge clk);

            // R7: payload beats pass through with ready high.
            for (int i = 0; i < blen; i++) begin
                chk(pl_ready && hs_en && hs_byte == bdat[i], "R7", hs_byte, bdat[i]);
                @(posedge clk); #1;
                if (i == blen - 1) begin
                    pl_valid = 1'b0; pl_last = 1'b0;
                end else begin
                    pl_data = bdat[i+1];
                    pl_last = (i + 1 == blen - 1);
                end
                @(negedge clk);
            end

            // R8: trail level and length.
            n = 0;
            while (hs_en && !pl_ready && hs_byte == {8{~bdat[blen-1][7]}} && n < 100) begin
                n++; @(negedge clk);
            end
            chk(n == int'(cfg_trail) + 1, "R8", n, int'(cfg_trail) + 1);
            chk(lp_p && lp_n && !hs_en, "R8", {lp_p, lp_n, hs_en}, 3'b110);

            exp_gap = ((cfg_exit == 0) ? 1 : int'(cfg_exit)) + 1;
            if (k < NB - 1) setup_burst(k + 1);
            else burst_req = 1'b0;
        end

        // R9: with no request the lane remains in the stop state.
        for (int i = 0; i < 8; i++) begin
            chk(lp_p && lp_n && !hs_en && !pl_ready, "R9", {lp_p, lp_n, hs_en}, 3'b110);
            @(negedge clk);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nvec++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule